// File: doc/BRIEF.md
# Cluster Operand Routing Fabric

This block is the switching layer inside one compute cluster that holds a multiplier, a rotate-mode CORDIC, a vector-mode CORDIC and an ALU. Every operand input of those units gets its value from a private selector. The selector can pick any result port of the units in the same cluster, or any of the values arriving from neighbouring clusters. Between each selector and its operand sits a programmable delay line. A value can therefore be held for a set number of cycles before the destination unit consumes it.

The selector codes and delay depths come from a configuration store with one entry per operand port for every step of a folded schedule. A step counter walks through the schedule while the cluster runs and wraps at the programmed folding factor. At each step the whole routing pattern can change, which lets several tasks share one unit over time. Configuration is loaded ahead of the run, through a write port that only accepts writes while the cluster is stopped.

Top module: `cluster_operand_router`

## Requirements
- R1: After a synchronous active-low reset, every store entry selects source code 7 (external input 0) with delay 0, the step counter is 0, the folding factor is 1 and the error flag is low, so every operand equals external input 0.
- R2: Source codes 0 to 6 select local result ports 0 to 6, codes 7 to 14 select external inputs 0 to 7, and code 15 drives the operand to zero.
- R3: Each operand port has its own selector and delay line; programming one port leaves every other port's operand unchanged.
- R4: With delay d (0 to 7) the operand equals the selector output of d clock edges earlier; d = 0 is a combinational pass-through.
- R5: While run enable is high the step counter advances on every edge and wraps to 0 after step fold-1; while run enable is low it is held at 0; a folding factor of 0 behaves as 1.
- R6: The select code and the delay of each port are taken from the store entry of the current step.
- R7: Entry writes and folding-factor writes are accepted only while run enable is low, and they take effect on the operands from the cycle after the write edge.
- R8: A write attempted while run enable is high leaves the store and the folding factor unchanged and raises the error output for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en_i | input | 1 | Run the schedule; blocks configuration writes |
| cfg_we_i | input | 1 | Write one store entry |
| cfg_step_i | input | 3 | Schedule step of the entry written |
| cfg_port_i | input | 4 | Operand port of the entry written |
| cfg_sel_i | input | 4 | Source code written |
| cfg_dly_i | input | 3 | Delay depth written |
| cfg_fold_we_i | input | 1 | Write the folding factor |
| cfg_fold_i | input | 4 | Folding factor value |
| loc_res_i | input | 112 | Seven local unit results, port k at bits 16k+15:16k |
| ext_in_i | input | 128 | Eight external inputs, input e at bits 16e+15:16e |
| operand_o | output | 160 | Ten operands, port p at bits 16p+15:16p |
| step_o | output | 3 | Current schedule step |
| cfg_err_o | output | 1 | Pulse after a rejected write |

## Verification
On every cycle, the embedded properties check four things: that the step counter stays below the effective folding factor and returns to 0 while stopped, that the store and the folding factor do not move while running, that the error output rises exactly after rejected writes, and that a one-cycle delay reproduces the previous selector output. The source decoding, the isolation between ports, the delay depths beyond one and the per-step switching of the whole routing pattern can only be shown by the bench's scenarios. Those scenarios drive distinct values on every source and compare each operand against hand-derived expectations.

// File: rtl/cor_pkg.sv
// Shared defaults and width helper for the cluster operand routing fabric.
// Assumes: consumers derive all field widths through clog2_min1.
package cor_pkg;
    localparam int unsigned DEF_DATA_W    = 16;
    localparam int unsigned DEF_N_LOC     = 7;
    localparam int unsigned DEF_N_EXT     = 8;
    localparam int unsigned DEF_N_PORTS   = 10;
    localparam int unsigned DEF_MAX_STEPS = 8;
    localparam int unsigned DEF_MAX_DLY   = 7;

    // Bits needed to index v items, never less than one.
    function automatic int unsigned clog2_min1(input int unsigned v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction
endpackage

// File: rtl/cor_src_mux.sv
// Source selector for one operand port.
// Code s < N_SRC passes source s; any other code yields zero.
// Assumes: sources are packed with source 0 in the lowest bits.
module cor_src_mux #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_SRC  = 15,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [N_SRC*DATA_W-1:0] src_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [DATA_W-1:0]       data_o
);
    // Decode the select code against every source slot.
    always_comb begin
        data_o = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (sel_i == SEL_W'(s)) begin
                data_o = src_i[s*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/cor_delay_line.sv
// Programmable hold buffer for one operand port.
// Depth 0 passes the input through; depth d returns the input seen d edges ago.
// Assumes: depth codes above MAX_DLY are clamped to MAX_DLY.
module cor_delay_line #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned MAX_DLY = 7,
    parameter int unsigned DLY_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    generate
        if (MAX_DLY == 0) begin : g_pass
            logic unused_dly;
            assign unused_dly = ^dly_i;
            assign data_o     = data_i;
        end else begin : g_shift
            logic [MAX_DLY-1:0][DATA_W-1:0] sh_q;
            logic [DLY_W-1:0]               dly_c;
            logic                           warm_q;

            // Shift the selector output one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q <= '0;
                end else begin
                    sh_q[0] <= data_i;
                    for (int i = 1; i < MAX_DLY; i++) begin
                        sh_q[i] <= sh_q[i-1];
                    end
                end
            end

            // Note the first edge out of reset so history checks are valid.
            always_ff @(posedge clk) begin
                if (!rst_n) warm_q <= 1'b0;
                else        warm_q <= 1'b1;
            end

            // Pick the tap that matches the programmed depth.
            always_comb begin
                dly_c = (32'(dly_i) > MAX_DLY) ? DLY_W'(MAX_DLY) : dly_i;
                if (dly_c == '0) data_o = data_i;
                else             data_o = sh_q[DLY_W'(dly_c - 1'b1)];
            end

            p_one_cycle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q && dly_i == DLY_W'(1)) |-> (data_o == $past(data_i)));
        end
    endgenerate
endmodule

// File: rtl/cor_cfg_store.sv
// Schedule-indexed configuration store, folding factor and step counter.
// Holds one select code and one delay depth per operand port per step and
// presents the entries of the current step. Writes land only while stopped.
// Assumes: entries with out-of-range step or port addresses are dropped.
module cor_cfg_store #(
    parameter int unsigned N_PORTS   = 10,
    parameter int unsigned MAX_STEPS = 8,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned DLY_W     = 3,
    parameter int unsigned STEP_W    = 3,
    parameter int unsigned PORT_W    = 4,
    parameter int unsigned FOLD_W    = 4,
    parameter int unsigned RST_SEL   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en_i,
    input  logic                     cfg_we_i,
    input  logic [STEP_W-1:0]        cfg_step_i,
    input  logic [PORT_W-1:0]        cfg_port_i,
    input  logic [SEL_W-1:0]         cfg_sel_i,
    input  logic [DLY_W-1:0]         cfg_dly_i,
    input  logic                     cfg_fold_we_i,
    input  logic [FOLD_W-1:0]        cfg_fold_i,
    output logic [N_PORTS*SEL_W-1:0] cur_sel_o,
    output logic [N_PORTS*DLY_W-1:0] cur_dly_o,
    output logic [STEP_W-1:0]        step_o,
    output logic                     cfg_err_o
);
    localparam logic [FOLD_W-1:0] FOLD_LIM = FOLD_W'(MAX_STEPS);
    localparam logic [SEL_W-1:0]  SEL_RST  = SEL_W'(RST_SEL);

    logic [MAX_STEPS-1:0][N_PORTS-1:0][SEL_W-1:0] sel_mem_q;
    logic [MAX_STEPS-1:0][N_PORTS-1:0][DLY_W-1:0] dly_mem_q;
    logic [FOLD_W-1:0] fold_q;
    logic [FOLD_W-1:0] fold_eff;
    logic [STEP_W-1:0] step_q;
    logic              err_q;
    logic              entry_ok;
    logic              fold_ok;

    // Qualify writes: stopped and inside the store.
    always_comb begin
        entry_ok = cfg_we_i && !run_en_i
                   && (32'(cfg_step_i) < MAX_STEPS)
                   && (32'(cfg_port_i) < N_PORTS);
        fold_ok  = cfg_fold_we_i && !run_en_i;
    end

    // Map the stored folding factor onto 1..MAX_STEPS.
    always_comb begin
        if (fold_q == '0)            fold_eff = FOLD_W'(1);
        else if (fold_q > FOLD_LIM)  fold_eff = FOLD_LIM;
        else                         fold_eff = fold_q;
    end

    // Entry storage with reset to the default route.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < MAX_STEPS; s++) begin
                for (int p = 0; p < N_PORTS; p++) begin
                    sel_mem_q[s][p] <= SEL_RST;
                    dly_mem_q[s][p] <= '0;
                end
            end
        end else if (entry_ok) begin
            sel_mem_q[cfg_step_i][cfg_port_i] <= cfg_sel_i;
            dly_mem_q[cfg_step_i][cfg_port_i] <= cfg_dly_i;
        end
    end

    // Folding factor register.
    always_ff @(posedge clk) begin
        if (!rst_n)       fold_q <= FOLD_W'(1);
        else if (fold_ok) fold_q <= cfg_fold_i;
    end

    // Step counter: runs and wraps while enabled, parked at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en_i)                      step_q <= '0;
        else if (FOLD_W'(step_q) >= fold_eff - 1'b1)  step_q <= '0;
        else                                          step_q <= step_q + 1'b1;
    end

    // One-cycle flag for a write attempted while running.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= run_en_i && (cfg_we_i || cfg_fold_we_i);
    end

    // Present the current step's entries for every port.
    always_comb begin
        for (int p = 0; p < N_PORTS; p++) begin
            cur_sel_o[p*SEL_W +: SEL_W] = sel_mem_q[step_q][p];
            cur_dly_o[p*DLY_W +: DLY_W] = dly_mem_q[step_q][p];
        end
    end

    assign step_o    = step_q;
    assign cfg_err_o = err_q;

    p_step_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> (step_o == '0));
    p_step_in_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        FOLD_W'(step_o) < fold_eff);
    p_store_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_en_i |=> ($stable(sel_mem_q) && $stable(dly_mem_q) && $stable(fold_q)));
    p_err_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && (cfg_we_i || cfg_fold_we_i)) |=> cfg_err_o);
    p_err_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(run_en_i));
endmodule

// File: rtl/cluster_operand_router.sv
// Operand routing fabric of one compute cluster.
// Every operand port owns a source selector over local results and external
// inputs, followed by a programmable delay line; both are driven from the
// schedule-indexed configuration store.
// Assumes: source code order is local results first, then external inputs.
module cluster_operand_router #(
    parameter int unsigned DATA_W    = cor_pkg::DEF_DATA_W,
    parameter int unsigned N_LOC     = cor_pkg::DEF_N_LOC,
    parameter int unsigned N_EXT     = cor_pkg::DEF_N_EXT,
    parameter int unsigned N_PORTS   = cor_pkg::DEF_N_PORTS,
    parameter int unsigned MAX_STEPS = cor_pkg::DEF_MAX_STEPS,
    parameter int unsigned MAX_DLY   = cor_pkg::DEF_MAX_DLY,
    localparam int unsigned N_SRC    = N_LOC + N_EXT,
    localparam int unsigned SEL_W    = cor_pkg::clog2_min1(N_SRC + 1),
    localparam int unsigned DLY_W    = cor_pkg::clog2_min1(MAX_DLY + 1),
    localparam int unsigned STEP_W   = cor_pkg::clog2_min1(MAX_STEPS),
    localparam int unsigned PORT_W   = cor_pkg::clog2_min1(N_PORTS),
    localparam int unsigned FOLD_W   = cor_pkg::clog2_min1(MAX_STEPS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_en_i,
    input  logic                      cfg_we_i,
    input  logic [STEP_W-1:0]         cfg_step_i,
    input  logic [PORT_W-1:0]         cfg_port_i,
    input  logic [SEL_W-1:0]          cfg_sel_i,
    input  logic [DLY_W-1:0]          cfg_dly_i,
    input  logic                      cfg_fold_we_i,
    input  logic [FOLD_W-1:0]         cfg_fold_i,
    input  logic [N_LOC*DATA_W-1:0]   loc_res_i,
    input  logic [N_EXT*DATA_W-1:0]   ext_in_i,
    output logic [N_PORTS*DATA_W-1:0] operand_o,
    output logic [STEP_W-1:0]         step_o,
    output logic                      cfg_err_o
);
    logic [N_SRC*DATA_W-1:0]   src_all;
    logic [N_PORTS*SEL_W-1:0]  cur_sel;
    logic [N_PORTS*DLY_W-1:0]  cur_dly;

    assign src_all = {ext_in_i, loc_res_i};

    cor_cfg_store #(
        .N_PORTS   (N_PORTS),
        .MAX_STEPS (MAX_STEPS),
        .SEL_W     (SEL_W),
        .DLY_W     (DLY_W),
        .STEP_W    (STEP_W),
        .PORT_W    (PORT_W),
        .FOLD_W    (FOLD_W),
        .RST_SEL   (N_LOC)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en_i      (run_en_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_step_i    (cfg_step_i),
        .cfg_port_i    (cfg_port_i),
        .cfg_sel_i     (cfg_sel_i),
        .cfg_dly_i     (cfg_dly_i),
        .cfg_fold_we_i (cfg_fold_we_i),
        .cfg_fold_i    (cfg_fold_i),
        .cur_sel_o     (cur_sel),
        .cur_dly_o     (cur_dly),
        .step_o        (step_o),
        .cfg_err_o     (cfg_err_o)
    );

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            logic [DATA_W-1:0] picked;

            cor_src_mux #(
                .DATA_W (DATA_W),
                .N_SRC  (N_SRC),
                .SEL_W  (SEL_W)
            ) u_mux (
                .src_i  (src_all),
                .sel_i  (cur_sel[p*SEL_W +: SEL_W]),
                .data_o (picked)
            );

            cor_delay_line #(
                .DATA_W  (DATA_W),
                .MAX_DLY (MAX_DLY),
                .DLY_W   (DLY_W)
            ) u_dly (
                .clk    (clk),
                .rst_n  (rst_n),
                .dly_i  (cur_dly[p*DLY_W +: DLY_W]),
                .data_i (picked),
                .data_o (operand_o[p*DATA_W +: DATA_W])
            );
        end
    endgenerate
endmodule

// File: tb/cluster_operand_router_tb.sv
// Self-checking bench: table of routing vectors, then directed scenarios.
module cluster_operand_router_tb;
    localparam int DW = 16;
    localparam int NL = 7;
    localparam int NE = 8;
    localparam int NP = 10;
    localparam int NV = 8;
    // Vector fields: [23:20] port, [19:16] source code, [15:0] expected operand.
    localparam logic [23:0] VEC [NV] = '{
        24'h0_3_1003, 24'h1_7_2000, 24'h2_E_2007, 24'h3_F_0000,
        24'h4_0_1000, 24'h9_6_1006, 24'h5_A_2003, 24'h0_8_2001
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run_en = 1'b0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_step = '0;
    logic [3:0]      cfg_port = '0;
    logic [3:0]      cfg_sel = '0;
    logic [2:0]      cfg_dly = '0;
    logic            cfg_fold_we = 1'b0;
    logic [3:0]      cfg_fold = '0;
    logic [NL*DW-1:0] loc;
    logic [NE*DW-1:0] ext;
    logic [NP*DW-1:0] operand;
    logic [2:0]      step;
    logic            cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] shadow [NP];

    always #4 clk = ~clk;

    cluster_operand_router u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en_i      (run_en),
        .cfg_we_i      (cfg_we),
        .cfg_step_i    (cfg_step),
        .cfg_port_i    (cfg_port),
        .cfg_sel_i     (cfg_sel),
        .cfg_dly_i     (cfg_dly),
        .cfg_fold_we_i (cfg_fold_we),
        .cfg_fold_i    (cfg_fold),
        .loc_res_i     (loc),
        .ext_in_i      (ext),
        .operand_o     (operand),
        .step_o        (step),
        .cfg_err_o     (cfg_err)
    );

    function automatic logic [15:0] op(input int p);
        return operand[p*DW +: DW];
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic write_entry(input int s, input int p, input int code, input int d);
        cfg_step = 3'(s);
        cfg_port = 4'(p);
        cfg_sel  = 4'(code);
        cfg_dly  = 3'(d);
        cfg_we   = 1'b1;
        tick();
        cfg_we   = 1'b0;
        #1;
    endtask

    task automatic write_fold(input int f);
        cfg_fold    = 4'(f);
        cfg_fold_we = 1'b1;
        tick();
        cfg_fold_we = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NL; k++) loc[k*DW +: DW] = 16'(16'h1000 + k);
        for (int e = 0; e < NE; e++) ext[e*DW +: DW] = 16'(16'h2000 + e);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        #1;

        // R1: reset routes every port to external input 0, step 0, no error.
        for (int p = 0; p < NP; p++) begin
            chk("R1", op(p), 16'h2000);
            shadow[p] = 16'h2000;
        end
        chk("R1", 16'(step), 16'h0000);
        chk("R1", 16'(cfg_err), 16'h0000);

        // R2/R3: table walk; each write checked on its port and all others.
        for (int v = 0; v < NV; v++) begin
            write_entry(0, int'(VEC[v][23:20]), int'(VEC[v][19:16]), 0);
            shadow[VEC[v][23:20]] = VEC[v][15:0];
            for (int p = 0; p < NP; p++) begin
                chk((p == int'(VEC[v][23:20])) ? "R2" : "R3", op(p), shadow[p]);
            end
        end

        // R4: depth 3 on port 0 from local result 2.
        write_entry(0, 0, 2, 3);
        repeat (8) tick();
        #1;
        chk("R4", op(0), 16'h1002);
        loc[2*DW +: DW] = 16'hBEEF;
        #1;
        chk("R4", op(0), 16'h1002);
        tick(); #1; chk("R4", op(0), 16'h1002);
        tick(); #1; chk("R4", op(0), 16'h1002);
        tick(); #1; chk("R4", op(0), 16'hBEEF);

        // R5/R6: three-step schedule on port 1.
        write_entry(0, 1, 0, 0);
        write_entry(1, 1, 1, 0);
        write_entry(2, 1, 10, 0);
        write_fold(3);
        chk("R7", op(1), 16'h1000);
        run_en = 1'b1;
        #1;
        chk("R5", 16'(step), 16'h0000);
        tick(); #1;
        chk("R5", 16'(step), 16'h0001);
        chk("R6", op(1), 16'h1001);
        chk("R6", op(0), 16'h2000);
        tick(); #1;
        chk("R5", 16'(step), 16'h0002);
        chk("R6", op(1), 16'h2003);
        tick(); #1;
        chk("R5", 16'(step), 16'h0000);
        chk("R6", op(1), 16'h1000);
        chk("R6", op(0), 16'hBEEF);

        // R8: entry write while running is dropped and flagged once.
        cfg_step = 3'd0; cfg_port = 4'd1; cfg_sel = 4'd14; cfg_dly = 3'd0;
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        #1;
        chk("R8", 16'(cfg_err), 16'h0001);
        tick(); #1;
        chk("R8", 16'(cfg_err), 16'h0000);
        tick(); #1;
        chk("R8", 16'(step), 16'h0000);
        chk("R8", op(1), 16'h1000);

        // R8: fold write while running is dropped; wrap stays at 3.
        cfg_fold = 4'd5;
        cfg_fold_we = 1'b1;
        tick();
        cfg_fold_we = 1'b0;
        #1;
        chk("R8", 16'(cfg_err), 16'h0001);
        tick(); #1; chk("R8", 16'(step), 16'h0002);
        tick(); #1; chk("R8", 16'(step), 16'h0000);

        // R5: stopping parks the counter at 0.
        run_en = 1'b0;
        tick(); tick(); #1;
        chk("R5", 16'(step), 16'h0000);

        // R5: folding factor 0 behaves as 1.
        write_fold(0);
        run_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(); #1;
            chk("R5", 16'(step), 16'h0000);
        end
        run_en = 1'b0;
        tick();

        // R7: once stopped, the same entry write is accepted.
        write_entry(0, 1, 14, 0);
        chk("R7", op(1), 16'h2007);
        chk("R7", 16'(cfg_err), 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule